// File: doc/BRIEF.md
# Parallel EEPROM page-write controller

This block writes pages into an asynchronous byte-wide parallel EEPROM. A host first hands over a start address and a byte count on a request handshake. It then streams the bytes on a second valid/ready handshake. The controller drives the memory's address, data, chip-enable, write-enable and output-enable pins. Every strobe is timed in system clock cycles, and those cycle counts are derived from nanosecond parameters together with a clock-period parameter.

All bytes of one request belong to one 128-byte page. Successive write-enable pulses are spaced no closer than the minimum load spacing and no further apart than the load window. After the last byte, the controller waits out the self-timed programming interval before it accepts the next request. If the host stalls past the window, the page is closed early. A request that would leave its page is refused. After reset, a lockout interval holds off all writes. The `busy` output stays high whenever the controller cannot take a request.

Top module: `eeprom_page_writer`

## Requirements
- R1: While reset is high, and for exactly ceil(LOCK_NS/CLK_NS) clock edges after reset is released (5000 edges at the default parameters), `busy` is 1, `req_ready` is 0 and `mem_we_n`/`mem_ce_n`/`mem_oe_n` stay 1. On the next edge, `busy` drops and `req_ready` rises.
- R2: Each write-enable low pulse lasts exactly max(ceil(WE_LOW_NS/CLK_NS), ceil(DATA_SETUP_NS/CLK_NS)) cycles (13 at defaults). Throughout the pulse, `mem_ce_n` is 0 and `mem_oe_n` is 1.
- R3: `mem_addr` and `mem_dq` are set one cycle before `mem_we_n` falls. They stay unchanged through the pulse and for at least one cycle after `mem_we_n` rises.
- R4: Within one page, successive `mem_we_n` falling edges are at least ceil(LOAD_GAP_MIN_NS/CLK_NS) cycles apart (50) and at most floor(LOAD_GAP_MAX_NS/CLK_NS) cycles apart (1500). A byte offered in the last cycle of the window is still loaded.
- R5: The i-th byte of a request (counting from 0) is written at address `req_addr + i`, with the data accepted i-th. Address bits [16:7] stay fixed for the whole request.
- R6: A request with `req_len` equal to 0, or with `req_addr[6:0] + req_len` greater than 128, is refused. `req_err` is 1 in exactly the one cycle after acceptance. No write-enable pulse follows, and `busy` stays 0.
- R7: After the last load of a page, `busy` stays 1 and `req_ready` stays 0 for at least ceil(PROG_NS/CLK_NS) cycles. No new pulse starts before that interval has passed.
- R8: If at least one byte was loaded and no further byte is accepted within the window, the page closes. `dat_ready` drops, and `req_ready` returns exactly window + programming cycles after the last accepted byte. Later bytes are not taken.
- R9: If no byte arrives within the window after a request is accepted, the controller returns to idle with no programming wait. `req_ready` returns exactly window cycles after acceptance, and no pulse is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Page request offered |
| req_ready | output | 1 | Controller idle, request taken when valid |
| req_addr | input | 17 | Start byte address |
| req_len | input | 8 | Number of bytes, 1 to 128 |
| req_err | output | 1 | One-cycle pulse: request refused |
| dat_valid | input | 1 | Data byte offered |
| dat_ready | output | 1 | Controller can load a byte now |
| dat_byte | input | 8 | Data byte |
| busy | output | 1 | Lockout, page loading or programming in progress |
| mem_addr | output | 17 | Memory address pins |
| mem_dq | output | 8 | Memory data pins (write direction only) |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low, held high |

## Verification
Two functions can fall in the same cycle: the load-window timeout and the acceptance of a late data byte. The bench provokes this by offering a byte so that it is sampled on the exact edge where the window counter reaches its limit. It expects the byte to win, so the fall-to-fall spacing equals the full window. It then offers the next byte one edge later and expects that byte to be refused. That page must close with only the loads that were made, and `req_ready` must return at a cycle computed from the window and programming counts.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

  typedef enum logic [1:0] {
    PW_LOCK,
    PW_IDLE,
    PW_LOAD,
    PW_PROG
  } pw_state_t;

  typedef enum logic [1:0] {
    SB_IDLE,
    SB_SETUP,
    SB_LOW,
    SB_HOLD
  } sb_state_t;

  // Round a nanosecond interval up to whole clock cycles.
  function automatic int ns_to_cyc_up(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eepw_timer.sv
module eepw_timer #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  // Free-running up counter, saturating so long idle stretches never wrap.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt != '1) begin
      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/eepw_page_check.sv
module eepw_page_check #(
  parameter int ADDR_W    = 17,
  parameter int PAGE_BITS = 7,
  parameter int LEN_W     = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              fits
);
  localparam int EW       = LEN_W + 1;
  localparam int PAGE_LEN = 1 << PAGE_BITS;

  logic [EW-1:0] end_ofs;

  always_comb begin
    end_ofs = EW'(addr[PAGE_BITS-1:0]) + EW'(len);
    fits    = (len != '0) && (end_ofs <= EW'(PAGE_LEN));
  end
endmodule

// File: rtl/eepw_strobe.sv
module eepw_strobe
  import eepw_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int LOW_CYC  = 13,
  parameter int HOLD_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_data,
  output logic              idle,
  output logic [ADDR_W-1:0] pin_addr,
  output logic [DATA_W-1:0] pin_dq,
  output logic              pin_ce_n,
  output logic              pin_we_n
);
  localparam int CNT_W = $clog2(imax(LOW_CYC, HOLD_CYC) + 1);

  sb_state_t        st;
  logic [CNT_W-1:0] cnt;

  assign idle = (st == SB_IDLE);

  // Sequence: drive address, data and chip enable; one cycle later drop
  // write enable for LOW_CYC cycles; keep chip enable low HOLD_CYC more.
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SB_IDLE;
      cnt      <= '0;
      pin_addr <= '0;
      pin_dq   <= '0;
      pin_ce_n <= 1'b1;
      pin_we_n <= 1'b1;
    end else begin
      case (st)
        SB_IDLE: begin
          if (go) begin
            pin_addr <= go_addr;
            pin_dq   <= go_data;
            pin_ce_n <= 1'b0;
            st       <= SB_SETUP;
          end
        end
        SB_SETUP: begin
          pin_we_n <= 1'b0;
          cnt      <= CNT_W'(LOW_CYC - 1);
          st       <= SB_LOW;
        end
        SB_LOW: begin
          if (cnt == '0) begin
            pin_we_n <= 1'b1;
            cnt      <= CNT_W'(HOLD_CYC - 1);
            st       <= SB_HOLD;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: begin
          if (cnt == '0) begin
            pin_ce_n <= 1'b1;
            st       <= SB_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
      endcase
    end
  end

  // R2: write enable is never low without chip enable low.
  assert_we_inside_ce_R2: assert property (@(posedge clk) disable iff (rst)
    !pin_we_n |-> !pin_ce_n);

  // R3: pins stay put through the pulse and the cycle after its rise.
  assert_pins_stable_R3: assert property (@(posedge clk) disable iff (rst)
    !pin_we_n |=> ($stable(pin_addr) && $stable(pin_dq)));

  // R4: the controller issues a load only when the sequencer is free.
  assert_go_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
    go |-> (st == SB_IDLE));
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eepw_pkg::*;
#(
  parameter int CLK_NS          = 20,
  parameter int ADDR_W          = 17,
  parameter int DATA_W          = 8,
  parameter int PAGE_BITS       = 7,
  parameter int WE_LOW_NS       = 250,
  parameter int DATA_SETUP_NS   = 100,
  parameter int DATA_HOLD_NS    = 10,
  parameter int ADDR_HOLD_NS    = 150,
  parameter int LOAD_GAP_MIN_NS = 1000,
  parameter int LOAD_GAP_MAX_NS = 30000,
  parameter int PROG_NS         = 15000000,
  parameter int LOCK_NS         = 100000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [PAGE_BITS:0]      req_len,
  output logic                    req_err,
  input  logic                    dat_valid,
  output logic                    dat_ready,
  input  logic [DATA_W-1:0]       dat_byte,
  output logic                    busy,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]       mem_dq,
  output logic                    mem_ce_n,
  output logic                    mem_we_n,
  output logic                    mem_oe_n
);
  localparam int LEN_W    = PAGE_BITS + 1;
  localparam int LOW_CYC  = imax(ns_to_cyc_up(WE_LOW_NS, CLK_NS),
                                 ns_to_cyc_up(DATA_SETUP_NS, CLK_NS));
  localparam int HOLD_CYC = imax(1, imax(ns_to_cyc_up(DATA_HOLD_NS, CLK_NS),
                                 ns_to_cyc_up(ADDR_HOLD_NS, CLK_NS) - LOW_CYC));
  localparam int GAP_CYC  = imax(1, ns_to_cyc_up(LOAD_GAP_MIN_NS, CLK_NS));
  localparam int WIN_CYC  = LOAD_GAP_MAX_NS / CLK_NS;
  localparam int PROG_CYC = imax(1, ns_to_cyc_up(PROG_NS, CLK_NS));
  localparam int LOCK_CYC = imax(1, ns_to_cyc_up(LOCK_NS, CLK_NS));
  localparam int TMR_MAX  = imax(PROG_CYC, imax(LOCK_CYC, WIN_CYC));
  localparam int TMR_W    = $clog2(TMR_MAX + 2);
  localparam int PAGE_W   = ADDR_W - PAGE_BITS;

  pw_state_t            st, st_n;
  logic [TMR_W-1:0]     tmr;
  logic                 tmr_clr;
  logic [PAGE_W-1:0]    page_q;
  logic [PAGE_BITS-1:0] ofs_q;
  logic [LEN_W-1:0]     left_q;
  logic                 first_q;
  logic                 loaded_q;
  logic                 oe_n_q;
  logic                 fits;
  logic                 acc_req;
  logic                 go;
  logic                 sb_idle;
  logic                 gap_ok;
  logic                 win_out;

  eepw_timer #(.W(TMR_W)) u_tmr (
    .clk (clk),
    .rst (rst),
    .clr (tmr_clr),
    .cnt (tmr)
  );

  eepw_page_check #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .LEN_W     (LEN_W)
  ) u_chk (
    .addr (req_addr),
    .len  (req_len),
    .fits (fits)
  );

  eepw_strobe #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LOW_CYC  (LOW_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_sb (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .go_addr  ({page_q, ofs_q}),
    .go_data  (dat_byte),
    .idle     (sb_idle),
    .pin_addr (mem_addr),
    .pin_dq   (mem_dq),
    .pin_ce_n (mem_ce_n),
    .pin_we_n (mem_we_n)
  );

  assign req_ready = (st == PW_IDLE);
  assign acc_req   = req_valid && req_ready;
  assign gap_ok    = first_q || (tmr >= TMR_W'(GAP_CYC - 1));
  assign win_out   = (tmr >= TMR_W'(WIN_CYC - 1));
  assign dat_ready = (st == PW_LOAD) && sb_idle && (left_q != '0) && gap_ok;
  assign go        = dat_valid && dat_ready;
  assign mem_oe_n  = oe_n_q;

  // Next state; a byte that arrives on the window's last cycle wins.
  always_comb begin
    st_n    = st;
    tmr_clr = 1'b0;
    case (st)
      PW_LOCK: begin
        if (tmr == TMR_W'(LOCK_CYC - 1)) st_n = PW_IDLE;
      end
      PW_IDLE: begin
        if (acc_req && fits) begin
          st_n    = PW_LOAD;
          tmr_clr = 1'b1;
        end
      end
      PW_LOAD: begin
        if (go) begin
          tmr_clr = 1'b1;
        end else if (sb_idle && (left_q == '0)) begin
          st_n    = PW_PROG;
          tmr_clr = 1'b1;
        end else if (sb_idle && win_out) begin
          st_n    = loaded_q ? PW_PROG : PW_IDLE;
          tmr_clr = 1'b1;
        end
      end
      default: begin
        if (tmr == TMR_W'(PROG_CYC - 1)) st_n = PW_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= PW_LOCK;
      busy     <= 1'b1;
      req_err  <= 1'b0;
      page_q   <= '0;
      ofs_q    <= '0;
      left_q   <= '0;
      first_q  <= 1'b0;
      loaded_q <= 1'b0;
      oe_n_q   <= 1'b1;
    end else begin
      st      <= st_n;
      busy    <= (st_n != PW_IDLE);
      req_err <= acc_req && !fits;
      oe_n_q  <= 1'b1;
      if (acc_req && fits) begin
        page_q   <= req_addr[ADDR_W-1:PAGE_BITS];
        ofs_q    <= req_addr[PAGE_BITS-1:0];
        left_q   <= req_len;
        first_q  <= 1'b1;
        loaded_q <= 1'b0;
      end
      if (go) begin
        ofs_q    <= ofs_q + PAGE_BITS'(1);
        left_q   <= left_q - LEN_W'(1);
        first_q  <= 1'b0;
        loaded_q <= 1'b1;
      end
    end
  end

  // R1: no strobe while the post-reset lockout runs.
  assert_lock_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (st == PW_LOCK) |-> (mem_we_n && mem_ce_n));

  // R5: every falling write enable carries the latched page number.
  assert_page_fixed_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> (mem_addr[ADDR_W-1:PAGE_BITS] == page_q));

  // R6: a refusal leaves the controller idle and the pins quiet.
  assert_refuse_idle_R6: assert property (@(posedge clk) disable iff (rst)
    req_err |-> (!busy && mem_we_n));

  // R7: the programming wait never overlaps a write pulse.
  assert_prog_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (st == PW_PROG) |-> (mem_we_n && mem_ce_n && busy));
endmodule

// File: tb/eeprom_page_writer_tb_top.sv
`timescale 1ns/1ps
module eeprom_page_writer_tb_top;
  localparam int  CLK_NS   = 20;
  localparam int  PROG_NS  = 40000;
  localparam int  LOCK_CYC = 5000;
  localparam int  LOW_CYC  = 13;
  localparam int  GAP_CYC  = 50;
  localparam int  WIN_CYC  = 1500;
  localparam int  PROG_CYC = 2000;
  localparam int  NVEC     = 8;
  // {expect_refuse, length, start address}
  localparam logic [25:0] VECS [0:NVEC-1] = '{
    {1'b0, 8'd4,   17'h00000},
    {1'b0, 8'd128, 17'h1FF80},
    {1'b0, 8'd3,   17'h00105},
    {1'b0, 8'd1,   17'h0007F},
    {1'b1, 8'd2,   17'h0007F},
    {1'b1, 8'd0,   17'h00010},
    {1'b0, 8'd64,  17'h12340},
    {1'b1, 8'd64,  17'h12341}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic        req_err;
  logic        dat_valid = 1'b0;
  logic        dat_ready;
  logic [7:0]  dat_byte = '0;
  logic        busy;
  logic [16:0] mem_addr;
  logic [7:0]  mem_dq;
  logic        mem_ce_n, mem_we_n, mem_oe_n;

  always #10 clk = ~clk;

  eeprom_page_writer #(.CLK_NS(CLK_NS), .PROG_NS(PROG_NS)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_err(req_err),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
    .busy(busy), .mem_addr(mem_addr), .mem_dq(mem_dq),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  int     checks = 0;
  int     errs = 0;
  longint cyc = 0;
  bit     finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Pin monitor: models the memory side and checks strobe timing.
  longint      rst_rel_cyc = 0;
  longint      last_fall = 0;
  longint      last_rise = 0;
  bit          have_rise = 0;
  bit          page_open = 0;
  bit          prev_we = 1;
  int          low_cnt = 0;
  int          nfalls = 0;
  logic [16:0] f_addr;
  logic [7:0]  f_dat;
  logic [16:0] log_addr [0:255];
  logic [7:0]  log_dat  [0:255];

  always @(negedge clk) begin
    if (rst) begin
      prev_we = 1'b1;
    end else begin
      if (prev_we && !mem_we_n) begin
        f_addr = mem_addr;
        f_dat  = mem_dq;
        log_addr[nfalls % 256] = mem_addr;
        log_dat[nfalls % 256]  = mem_dq;
        nfalls++;
        low_cnt = 1;
        chk(cyc - rst_rel_cyc > LOCK_CYC, "R1", "fall after lockout",
            cyc - rst_rel_cyc, LOCK_CYC);
        chk(!mem_ce_n && mem_oe_n, "R2", "ce low, oe high at fall",
            {mem_ce_n, mem_oe_n}, 2'b01);
        if (page_open) begin
          if (have_rise)
            chk(cyc - last_rise >= PROG_CYC, "R7", "programming wait",
                cyc - last_rise, PROG_CYC);
          page_open = 0;
        end else begin
          chk((cyc - last_fall >= GAP_CYC) && (cyc - last_fall <= WIN_CYC),
              "R4", "load spacing", cyc - last_fall, GAP_CYC);
        end
        last_fall = cyc;
      end else if (!prev_we && !mem_we_n) begin
        low_cnt++;
        chk(mem_addr == f_addr && mem_dq == f_dat && !mem_ce_n && mem_oe_n,
            "R3", "pins stable while low", {mem_addr, mem_dq}, {f_addr, f_dat});
      end else if (!prev_we && mem_we_n) begin
        chk(low_cnt == LOW_CYC, "R2", "pulse width", low_cnt, LOW_CYC);
        chk(mem_addr == f_addr && mem_dq == f_dat, "R3", "hold after rise",
            {mem_addr, mem_dq}, {f_addr, f_dat});
        last_rise = cyc;
        have_rise = 1;
      end
      prev_we = mem_we_n;
    end
  end

  function automatic logic [7:0] pat(input int v, input int i);
    return 8'(v * 37 + i * 11 + 5);
  endfunction

  task automatic send_req(input logic [16:0] a, input logic [7:0] n,
                          output longint acc_cyc);
    int k = 0;
    @(negedge clk);
    while (!req_ready && k < 20000) begin
      @(negedge clk);
      k++;
    end
    req_valid = 1'b1;
    req_addr  = a;
    req_len   = n;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    acc_cyc   = cyc;
  endtask

  task automatic send_byte(input logic [7:0] d, output longint acc_cyc);
    int k = 0;
    @(negedge clk);
    while (!dat_ready && k < 3000) begin
      @(negedge clk);
      k++;
    end
    dat_valid = 1'b1;
    dat_byte  = d;
    @(posedge clk);
    #1;
    dat_valid = 1'b0;
    acc_cyc   = cyc;
  endtask

  // Offer a byte so that it is sampled exactly wait_edges+1 edges later.
  task automatic send_byte_at(input logic [7:0] d, input int wait_edges,
                              output bit taken, output longint acc_cyc);
    repeat (wait_edges) @(posedge clk);
    @(negedge clk);
    dat_valid = 1'b1;
    dat_byte  = d;
    taken     = dat_ready;
    @(posedge clk);
    #1;
    dat_valid = 1'b0;
    acc_cyc   = cyc;
  endtask

  task automatic wait_idle(input longint from, output longint elapsed,
                           output bit busy_held);
    int k = 0;
    busy_held = 1;
    @(negedge clk);
    while (!req_ready && k < 20000) begin
      if (!busy) busy_held = 0;
      @(negedge clk);
      k++;
    end
    elapsed = cyc - from;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "WDOG", "run did not finish", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end

  initial begin : main
    longint t0, t1, el;
    bit     held, tk;
    int     base;
    logic [16:0] a;
    int     n;

    // Reset state and post-reset lockout (R1)
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(busy && !req_ready && mem_we_n && mem_ce_n && mem_oe_n, "R1",
        "reset state", {busy, req_ready, mem_we_n, mem_ce_n, mem_oe_n}, 5'b10111);
    rst = 1'b0;
    rst_rel_cyc = cyc;
    repeat (LOCK_CYC - 1) @(posedge clk);
    @(negedge clk);
    chk(busy && !req_ready, "R1", "still locked at last lock edge",
        {busy, req_ready}, 2'b10);
    @(posedge clk);
    @(negedge clk);
    chk(!busy && req_ready, "R1", "lockout ends", {busy, req_ready}, 2'b01);

    // Vector table: page writes and refusals (R5, R6, R7)
    for (int v = 0; v < NVEC; v++) begin
      a    = VECS[v][16:0];
      n    = int'(VECS[v][24:17]);
      base = nfalls;
      if (VECS[v][25]) begin
        send_req(a, 8'(n), t0);
        @(negedge clk);
        chk(req_err == 1'b1 && !busy, "R6", "refusal pulse", {req_err, busy}, 2'b10);
        @(negedge clk);
        chk(req_err == 1'b0, "R6", "refusal one cycle", req_err, 0);
        repeat (100) @(negedge clk);
        chk(nfalls == base && !busy, "R6", "no strobes after refusal",
            nfalls - base, 0);
      end else begin
        page_open = 1;
        send_req(a, 8'(n), t0);
        @(negedge clk);
        chk(req_err == 1'b0, "R6", "accepted request no error", req_err, 0);
        for (int i = 0; i < n; i++) send_byte(pat(v, i), t1);
        wait_idle(t1, el, held);
        chk(el >= PROG_CYC && held, "R7", "busy through programming", el, PROG_CYC);
        chk(nfalls - base == n, "R5", "load count", nfalls - base, n);
        for (int i = 0; i < n; i++) begin
          chk(log_addr[(base + i) % 256] == 17'(a + 17'(i)), "R5", "load address",
              log_addr[(base + i) % 256], 17'(a + 17'(i)));
          chk(log_dat[(base + i) % 256] == pat(v, i), "R5", "load data",
              log_dat[(base + i) % 256], pat(v, i));
        end
      end
    end

    // Timeout tie: byte on the window's last edge wins, one edge later loses (R4, R8)
    base = nfalls;
    page_open = 1;
    send_req(17'h001A0, 8'd4, t0);
    send_byte(8'hA1, t1);
    send_byte_at(8'hA2, WIN_CYC - 1, tk, t1);
    chk(tk, "R4", "byte on last window cycle taken", tk, 1);
    send_byte_at(8'hA3, WIN_CYC, tk, t0);
    chk(!tk, "R8", "byte after window refused", tk, 0);
    wait_idle(t1, el, held);
    chk(el == WIN_CYC + PROG_CYC && held, "R8", "close and program time",
        el, WIN_CYC + PROG_CYC);
    chk(nfalls - base == 2, "R8", "loads in closed page", nfalls - base, 2);
    chk(log_addr[(base + 1) % 256] == 17'h001A1 && log_dat[(base + 1) % 256] == 8'hA2,
        "R4", "tie byte written", log_dat[(base + 1) % 256], 8'hA2);

    // Timeout with no byte at all (R9)
    base = nfalls;
    page_open = 1;
    send_req(17'h05000, 8'd8, t0);
    wait_idle(t0, el, held);
    chk(el == WIN_CYC && held, "R9", "empty request returns", el, WIN_CYC);
    chk(nfalls == base, "R9", "no strobe on empty request", nfalls - base, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule